// File: doc/BRIEF.md
# DRAM refresh and wake-up sequencer

This block keeps an asynchronous DRAM's contents alive and brings the device up after reset. Once reset is released, it waits for a power-up pause. It then asks the access controller for the memory pins and runs a burst of refresh cycles. Only after that burst does it raise `ready`, which lets host traffic reach the memory.

Each refresh is a CAS-before-RAS cycle. The DRAM's own row counter picks the row, so the block drives no address, and write-enable is held inactive (high) so that the device never enters its test mode. After start-up, an interval timer creates one pending refresh for every slice of the retention period. The slice is the retention time divided by the number of rows. Pending refreshes are counted in a backlog and served whenever the controller grants the pins.

If the controller withholds grants for so long that the backlog would pass its limit, the deadline is treated as missed. The block then sets a flag, drops `ready`, discards the backlog and repeats the whole wake-up burst.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and for PWRUP_CYCLES clock cycles after reset is released, ras_n and cas_n are 1, ref_req, ready and deadline_miss are 0. ref_req first reads 1 right after the PWRUP_CYCLES-th rising edge.
- R2: A strobe sequence starts only on the edge after a cycle in which ref_req and ref_gnt are both 1. While ref_gnt stays 0, ras_n and cas_n stay 1 and ref_req stays 1. ref_req is 0 while a sequence runs.
- R3: Each sequence drives cas_n low with ras_n high for T_CSR cycles. It then drives ras_n low for T_RAS cycles, with cas_n low for the first T_CHR of them and high for the rest. It then holds both high for T_RP cycles before ref_req can return.
- R4: we_n is 1 in every cycle.
- R5: ready stays 0 until WAKE_COUNT complete sequences have run after the power-up pause. It reads 1 in the cycle that follows the last precharge cycle of the final one.
- R6: After the power-up pause, the interval timer adds one pending refresh every REFI_CYCLES cycles, counted from the first cycle after the pause. The first one raises ref_req (with nothing else pending) right after edge PWRUP_CYCLES + REFI_CYCLES.
- R7: When a timer event arrives while BACKLOG_MAX refreshes are already pending, several things happen on that edge. deadline_miss becomes 1, ready becomes 0, the backlog is cleared and WAKE_COUNT wake-up sequences become due. deadline_miss returns to 0 and ready returns to 1 after the last of them completes. deadline_miss is never 1 while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh wanted; ownership of the DRAM pins requested |
| ref_gnt | input | 1 | Access controller hands the DRAM pins to this block |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| ready | output | 1 | Initialisation complete; host traffic may proceed |
| deadline_miss | output | 1 | Backlog exceeded its limit; wake-up is being repeated |

## Verification
Several properties are checked on every cycle:
- A falling row strobe must be preceded by the column strobe being low for at least the setup time.
- Each row-strobe pulse has exactly the programmed width, and the row strobe is high for at least the precharge time before it falls.
- The column strobe only falls after a granted request.
- The miss flag never coexists with ready.

Only the bench scenarios can show the remaining behaviour:
- The exact power-up pause and the exact timer period.
- That ready waits for precisely the wake-up count.
- That a withheld grant freezes the strobes.
- The exact edge on which the backlog overflows and the wake-up burst restarts.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int REFI_CYCLES  = 3900,
  parameter int PWRUP_CYCLES = 25000,
  parameter int WAKE_COUNT   = 8,
  parameter int BACKLOG_MAX  = 8,
  parameter int T_CSR        = 3,
  parameter int T_CHR        = 4,
  parameter int T_RAS        = 18,
  parameter int T_RP         = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready,
  output logic deadline_miss
);

  localparam int M1 = (PWRUP_CYCLES > T_RAS) ? PWRUP_CYCLES : T_RAS;
  localparam int M2 = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int CW = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int TW = $clog2(REFI_CYCLES + 1);
  localparam int WW = $clog2(WAKE_COUNT + 1);
  localparam int BW = $clog2(BACKLOG_MAX + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_CSR, S_ACT, S_PRE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [BW-1:0] backlog;
  logic [WW-1:0] wake_left;
  logic          missed;

  wire tick     = (st != S_PWR) && (tmr == TW'(REFI_CYCLES - 1));
  wire seq_done = (st == S_PRE) && (cnt == CW'(T_RP - 1));
  wire overflow = tick && (backlog == BW'(BACKLOG_MAX));
  wire in_wake  = (wake_left != '0);

  assign ref_req       = (st == S_IDLE) && (in_wake || backlog != '0);
  assign ras_n         = (st != S_ACT);
  assign cas_n         = !((st == S_CSR) || (st == S_ACT && cnt < CW'(T_CHR)));
  assign we_n          = 1'b1;
  assign ready         = (st != S_PWR) && !in_wake;
  assign deadline_miss = missed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_PWR;
      cnt <= '0;
    end else begin
      case (st)
        S_PWR:
          if (cnt == CW'(PWRUP_CYCLES - 1)) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_IDLE:
          if (ref_req && ref_gnt) begin st <= S_CSR; cnt <= '0; end
        S_CSR:
          if (cnt == CW'(T_CSR - 1)) begin st <= S_ACT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_ACT:
          if (cnt == CW'(T_RAS - 1)) begin st <= S_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_PRE:
          if (seq_done) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: begin st <= S_PWR; cnt <= '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_PWR) tmr <= '0;
    else if (tick)             tmr <= '0;
    else                       tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      backlog   <= '0;
      wake_left <= WW'(WAKE_COUNT);
      missed    <= 1'b0;
    end else if (overflow) begin
      backlog   <= '0;
      wake_left <= WW'(WAKE_COUNT);
      missed    <= 1'b1;
    end else begin
      if (seq_done && in_wake) begin
        wake_left <= wake_left - 1'b1;
        if (wake_left == WW'(1)) missed <= 1'b0;
      end
      if (tick && !(seq_done && !in_wake))      backlog <= backlog + 1'b1;
      else if (!tick && seq_done && !in_wake)   backlog <= backlog - 1'b1;
    end
  end

  logic [15:0] ras_lo_len, ras_hi_len, cas_lo_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_len <= '0;
      ras_hi_len <= '0;
      cas_lo_len <= '0;
    end else begin
      ras_lo_len <= ras_n  ? '0 : ((&ras_lo_len) ? ras_lo_len : ras_lo_len + 1'b1);
      ras_hi_len <= !ras_n ? '0 : ((&ras_hi_len) ? ras_hi_len : ras_hi_len + 1'b1);
      cas_lo_len <= cas_n  ? '0 : ((&cas_lo_len) ? cas_lo_len : cas_lo_len + 1'b1);
    end
  end

  a_r3_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && cas_lo_len >= 16'(T_CSR)));

  a_r3_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_len == 16'(T_RAS)));

  a_r3_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_len >= 16'(T_RP)));

  a_r2_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_req && ref_gnt));

  a_r7_miss_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_miss |-> !ready);

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int P    = 50;
  localparam int REFI = 200;
  localparam int WAKE = 8;
  localparam int BMAX = 2;

  logic clk = 1'b0;
  logic rst_n, ref_gnt;
  logic ref_req, ras_n, cas_n, we_n, ready, deadline_miss;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dram_refresh_seq #(
    .REFI_CYCLES(REFI), .PWRUP_CYCLES(P), .WAKE_COUNT(WAKE), .BACKLOG_MAX(BMAX),
    .T_CSR(2), .T_CHR(2), .T_RAS(5), .T_RP(3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready),
    .deadline_miss(deadline_miss)
  );

  // one row per cycle of a granted sequence: {gnt to drive, req, ras_n, cas_n}
  localparam logic [3:0] SEQ [11] = '{
    4'b1111, 4'b0010, 4'b0010, 4'b0000, 4'b0000,
    4'b0001, 4'b0001, 4'b0001, 4'b0011, 4'b0011, 4'b0011
  };

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic run_seq();
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      chk("R3 ras_n", ras_n, SEQ[i][1]);
      chk("R3 cas_n", cas_n, SEQ[i][0]);
      chk("R2 ref_req", ref_req, SEQ[i][2]);
      chk("R4 we_n", we_n, 1);
      ref_gnt = SEQ[i][3];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ras_n", ras_n, 1);
    chk("R1 reset cas_n", cas_n, 1);
    chk("R1 reset ref_req", ref_req, 0);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset deadline_miss", deadline_miss, 0);
    chk("R4 reset we_n", we_n, 1);
    rst_n = 1'b1;

    while (cyc < P - 1) @(negedge clk);
    chk("R1 pause ref_req", ref_req, 0);
    chk("R1 pause ras_n", ras_n, 1);
    chk("R1 pause cas_n", cas_n, 1);
    chk("R1 pause ready", ready, 0);
    @(negedge clk);
    chk("R1 first request edge", ref_req, 1);

    for (int w = 0; w < WAKE; w++) begin
      chk("R5 ready during wake-up", ready, 0);
      run_seq();
    end
    @(negedge clk);
    chk("R5 ready after wake-up", ready, 1);
    chk("R5 no pending after wake-up", ref_req, 0);
    chk("R7 miss clear after wake-up", deadline_miss, 0);

    while (!ref_req && cyc < P + REFI + 5) @(negedge clk);
    chk("R6 first timer request cycle", cyc, P + REFI);
    run_seq();
    @(negedge clk);
    chk("R6 ready kept", ready, 1);
    chk("R6 backlog served", ref_req, 0);

    while (!ref_req && cyc < P + 2 * REFI + 5) @(negedge clk);
    chk("R6 second timer request cycle", cyc, P + 2 * REFI);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R2 no grant ras_n", ras_n, 1);
      chk("R2 no grant cas_n", cas_n, 1);
      chk("R2 no grant ref_req", ref_req, 1);
    end

    while (!deadline_miss && cyc < P + 4 * REFI + 5) @(negedge clk);
    chk("R7 overflow cycle", cyc, P + 4 * REFI);
    chk("R7 ready dropped", ready, 0);
    chk("R7 wake-up requested", ref_req, 1);

    for (int w = 0; w < WAKE; w++) begin
      chk("R7 ready low during rewake", ready, 0);
      chk("R7 miss held during rewake", deadline_miss, 1);
      run_seq();
    end
    @(negedge clk);
    chk("R7 ready after rewake", ready, 1);
    chk("R7 miss cleared", deadline_miss, 0);
    chk("R7 backlog discarded", ref_req, 0);
    chk("R4 we_n end", we_n, 1);

    finish_run();
  end
endmodule